// File: doc/BRIEF.md
# Bit-Addressable I/O Register File

This block holds the control and status registers that a small processor core reaches through its I/O space. There are 64 registers of 8 bits each. A byte port writes and reads whole registers. The lower half of the space, addresses 0x00 to 0x1F, also accepts single-bit set and clear requests. It also answers single-bit test queries, which the core uses to decide whether to skip its next instruction.

Each bit of each register has a fixed kind, chosen by elaboration-time masks:
- a plain read/write bit;
- a status flag, which a peripheral raises through a per-bit set input and software clears by writing a one;
- a reserved bit, which always reads zero.

A single-bit operation changes only the selected bit. Clearing one flag with a bit operation therefore never wipes other pending flags in the same register.

Top module: `bitio_regfile`

## Requirements
- R1: A byte write (`wr_en`=1) at any address 0x00..0x3F loads the written value into the read/write bits of that register at the next clock edge. `rd_data` shows the register selected by `rd_addr` combinationally.
- R2: Reserved bits always read 0, and writes have no effect on them. With the default masks, the bit kinds depend on the address `a`. If `a[2:0]`=3'b111, the whole register is reserved (a reserved address). Otherwise, if `a[1:0]`=2'b01, bits 3..0 are flags, bit 7 is reserved and bits 6..4 are read/write. All other registers are read/write in every bit.
- R3: A flag bit is set at the next edge when its `flag_set` input is high. The `flag_set` index is `addr*8+bit`. A byte write with a 1 in a flag bit clears that flag, and a 0 leaves it unchanged. `flag_set` inputs of non-flag bits are ignored.
- R4: When a flag's `flag_set` input and a write-one clear hit that flag in the same cycle, the flag ends up set.
- R5: A bit operation (`bit_op_en`=1) at `bit_addr` < 0x20 acts on bit `bit_idx` only. For a read/write bit, it writes `bit_op_set` into that bit. For a flag bit, a set (`bit_op_set`=1) clears the flag and a clear has no effect. Every other bit of the register keeps its value.
- R6: A bit operation with `bit_addr` >= 0x20 is ignored.
- R7: For `test_addr` < 0x20, `test_valid`=1 and `test_bit` equals bit `test_idx` of that register. For higher addresses, both outputs are 0.
- R8: When `wr_en` and `bit_op_en` are both high in the same cycle, the byte write is performed and the bit operation is dropped.
- R9: After reset, every register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 6 | Byte write address |
| wr_data | input | 8 | Byte write data |
| rd_addr | input | 6 | Byte read address |
| rd_data | output | 8 | Byte read data |
| bit_op_en | input | 1 | Single-bit operation strobe |
| bit_op_set | input | 1 | 1 = set, 0 = clear |
| bit_addr | input | 6 | Bit operation register address |
| bit_idx | input | 3 | Bit operation bit index |
| test_addr | input | 6 | Bit test register address |
| test_idx | input | 3 | Bit test bit index |
| test_bit | output | 1 | Tested bit value |
| test_valid | output | 1 | Test address lies in the bit-addressable range |
| flag_set | input | 512 | Per-bit peripheral flag set pulses, index addr*8+bit |

## Verification
The bench aims at flag registers that mix flags, reserved bits and read/write bits. There, a design that performs a bit operation by reading the register and writing it back would clear neighbouring pending flags. A design that let a write-one clear beat a simultaneous peripheral set would lose an event. Bit operations and tests just above 0x1F are driven to catch a range check that is off by one or missing, which would let a bit operation modify an upper register or make a test report a bit there. Reserved addresses, and bit operations issued in the same cycle as a byte write, are also exercised to catch writes that leak into reserved storage or a wrong priority between the two ports.

// File: rtl/bitio_pkg.sv
package bitio_pkg;

   localparam int DEF_REGS = 64;
   localparam int DEF_W    = 8;

   typedef enum logic [1:0] {
      KIND_RW  = 2'd0,
      KIND_W1C = 2'd1,
      KIND_RSV = 2'd2
   } bit_kind_e;

   // Default per-bit kind for the standard 64 x 8 layout.
   function automatic bit_kind_e default_kind(input int addr, input int bitn);
      if ((addr % 8) == 7)
         return KIND_RSV;
      if ((addr % 4) == 1) begin
         if (bitn < 4)  return KIND_W1C;
         if (bitn == 7) return KIND_RSV;
      end
      return KIND_RW;
   endfunction

   function automatic logic [DEF_REGS*DEF_W-1:0] default_mask(input bit_kind_e kind);
      logic [DEF_REGS*DEF_W-1:0] m;
      m = '0;
      for (int a = 0; a < DEF_REGS; a++)
         for (int b = 0; b < DEF_W; b++)
            m[a*DEF_W+b] = (default_kind(a, b) == kind);
      return m;
   endfunction

endpackage

// File: rtl/bitio_decode.sv
module bitio_decode #(
   parameter int NUM_REGS = 64,
   parameter int BIT_REGS = 32,
   localparam int AW      = $clog2(NUM_REGS)
) (
   input  logic                wr_en,
   input  logic [AW-1:0]       wr_addr,
   input  logic                bit_op_en,
   input  logic [AW-1:0]       bit_addr,
   output logic [NUM_REGS-1:0] wr_sel,
   output logic [NUM_REGS-1:0] bop_sel
);

   logic bop_live;

   // A byte write in the same cycle takes precedence over a bit operation.
   assign bop_live = bit_op_en && !wr_en;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
      assign wr_sel[i] = wr_en && (wr_addr == AW'(i));
      if (i < BIT_REGS) begin : g_bitable
         assign bop_sel[i] = bop_live && (bit_addr == AW'(i));
      end else begin : g_plain
         assign bop_sel[i] = 1'b0;
      end
   end

endmodule

// File: rtl/bitio_cell.sv
module bitio_cell #(
   parameter int                DATA_W = 8,
   parameter logic [DATA_W-1:0] W1C    = '0,
   parameter logic [DATA_W-1:0] RSV    = '0,
   localparam int               IDX_W  = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              bop_hit,
   input  logic [IDX_W-1:0]  bop_idx,
   input  logic              bop_set,
   input  logic [DATA_W-1:0] flag_set,
   output logic [DATA_W-1:0] q
);

   localparam logic [DATA_W-1:0] RW = ~(W1C | RSV);

   logic [DATA_W-1:0] sel_oh;
   logic [DATA_W-1:0] rw_next;
   logic [DATA_W-1:0] w1c_clr;
   logic [DATA_W-1:0] w1c_next;
   logic [DATA_W-1:0] nxt;

   for (genvar b = 0; b < DATA_W; b++) begin : g_oh
      assign sel_oh[b] = (bop_idx == IDX_W'(b));
   end

   always_comb begin
      if (wr_hit)
         rw_next = wr_data;
      else if (bop_hit)
         rw_next = bop_set ? (q | sel_oh) : (q & ~sel_oh);
      else
         rw_next = q;
   end

   always_comb begin
      w1c_clr = '0;
      if (wr_hit)
         w1c_clr = wr_data;
      else if (bop_hit && bop_set)
         w1c_clr = sel_oh;
      // Peripheral set has priority over any clear.
      w1c_next = (q & ~w1c_clr) | flag_set;
   end

   assign nxt = ((RW & rw_next) | (W1C & w1c_next)) & ~RSV;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else
         q <= nxt;
   end

endmodule

// File: rtl/bitio_readmux.sv
module bitio_readmux #(
   parameter int NUM_REGS = 64,
   parameter int DATA_W   = 8,
   parameter int BIT_REGS = 32,
   localparam int AW      = $clog2(NUM_REGS),
   localparam int IDX_W   = $clog2(DATA_W)
) (
   input  logic [NUM_REGS*DATA_W-1:0] reg_flat,
   input  logic [AW-1:0]              rd_addr,
   output logic [DATA_W-1:0]          rd_data,
   input  logic [AW-1:0]              test_addr,
   input  logic [IDX_W-1:0]           test_idx,
   output logic                       test_bit,
   output logic                       test_valid
);

   logic [DATA_W-1:0] test_word;

   assign rd_data    = reg_flat[rd_addr*DATA_W +: DATA_W];
   assign test_word  = reg_flat[test_addr*DATA_W +: DATA_W];
   assign test_valid = ({1'b0, test_addr} < (AW+1)'(BIT_REGS));
   assign test_bit   = test_valid && test_word[test_idx];

endmodule

// File: rtl/bitio_regfile.sv
module bitio_regfile #(
   parameter int NUM_REGS = 64,
   parameter int DATA_W   = 8,
   parameter int BIT_REGS = 32,
   parameter logic [NUM_REGS*DATA_W-1:0] W1C_MASK =
      (NUM_REGS*DATA_W)'(bitio_pkg::default_mask(bitio_pkg::KIND_W1C)),
   parameter logic [NUM_REGS*DATA_W-1:0] RSV_MASK =
      (NUM_REGS*DATA_W)'(bitio_pkg::default_mask(bitio_pkg::KIND_RSV)),
   localparam int AW    = $clog2(NUM_REGS),
   localparam int IDX_W = $clog2(DATA_W),
   localparam int FLAT  = NUM_REGS*DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              bit_op_en,
   input  logic              bit_op_set,
   input  logic [AW-1:0]     bit_addr,
   input  logic [IDX_W-1:0]  bit_idx,
   input  logic [AW-1:0]     test_addr,
   input  logic [IDX_W-1:0]  test_idx,
   output logic              test_bit,
   output logic              test_valid,
   input  logic [FLAT-1:0]   flag_set
);

   // Elaboration-time parameter checks
   if (NUM_REGS != (1 << AW)) begin : g_bad_regs
      $error("NUM_REGS must be a power of two");
   end
   if (DATA_W != (1 << IDX_W)) begin : g_bad_width
      $error("DATA_W must be a power of two");
   end
   if (BIT_REGS > NUM_REGS || BIT_REGS < 1) begin : g_bad_bitregs
      $error("BIT_REGS must lie in 1..NUM_REGS");
   end
   if ((W1C_MASK & RSV_MASK) != '0) begin : g_bad_masks
      $error("a bit cannot be both flag and reserved");
   end

   logic [NUM_REGS-1:0] wr_sel;
   logic [NUM_REGS-1:0] bop_sel;
   logic [FLAT-1:0]     reg_flat;

   bitio_decode #(
      .NUM_REGS (NUM_REGS),
      .BIT_REGS (BIT_REGS)
   ) i_decode (
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .bit_op_en (bit_op_en),
      .bit_addr  (bit_addr),
      .wr_sel    (wr_sel),
      .bop_sel   (bop_sel)
   );

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      bitio_cell #(
         .DATA_W (DATA_W),
         .W1C    (W1C_MASK[r*DATA_W +: DATA_W]),
         .RSV    (RSV_MASK[r*DATA_W +: DATA_W])
      ) i_cell (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_hit   (wr_sel[r]),
         .wr_data  (wr_data),
         .bop_hit  (bop_sel[r]),
         .bop_idx  (bit_idx),
         .bop_set  (bit_op_set),
         .flag_set (flag_set[r*DATA_W +: DATA_W]),
         .q        (reg_flat[r*DATA_W +: DATA_W])
      );
   end

   bitio_readmux #(
      .NUM_REGS (NUM_REGS),
      .DATA_W   (DATA_W),
      .BIT_REGS (BIT_REGS)
   ) i_readmux (
      .reg_flat   (reg_flat),
      .rd_addr    (rd_addr),
      .rd_data    (rd_data),
      .test_addr  (test_addr),
      .test_idx   (test_idx),
      .test_bit   (test_bit),
      .test_valid (test_valid)
   );

endmodule

// File: rtl/bitio_regfile_chk.sv
module bitio_regfile_chk #(
   parameter int NUM_REGS = 64,
   parameter int DATA_W   = 8,
   parameter int BIT_REGS = 32,
   parameter logic [NUM_REGS*DATA_W-1:0] W1C_MASK = '0,
   parameter logic [NUM_REGS*DATA_W-1:0] RSV_MASK = '0,
   localparam int AW    = $clog2(NUM_REGS),
   localparam int IDX_W = $clog2(DATA_W),
   localparam int FLAT  = NUM_REGS*DATA_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              bit_op_en,
   input logic [AW-1:0]     bit_addr,
   input logic [AW-1:0]     rd_addr,
   input logic [DATA_W-1:0] rd_data,
   input logic [AW-1:0]     test_addr,
   input logic [IDX_W-1:0]  test_idx,
   input logic              test_bit,
   input logic              test_valid,
   input logic [FLAT-1:0]   flag_set,
   input logic [FLAT-1:0]   reg_flat
);

   logic bop_high;
   assign bop_high = ({1'b0, bit_addr} >= (AW+1)'(BIT_REGS));

   // R2
   rsv_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data & RSV_MASK[rd_addr*DATA_W +: DATA_W]) == '0);

   // R4
   flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((flag_set & W1C_MASK) != '0) |=>
         ((reg_flat & $past(flag_set & W1C_MASK)) == $past(flag_set & W1C_MASK)));

   // R5
   bit_op_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_op_en && !wr_en && flag_set == '0) |=>
         ($countones(reg_flat ^ $past(reg_flat)) <= 1));

   // R6
   bit_op_high_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_op_en && !wr_en && bop_high && flag_set == '0) |=> $stable(reg_flat));

   // R7
   test_matches_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (test_valid && rd_addr == test_addr) |-> (test_bit == rd_data[test_idx]));

   // R7
   test_invalid_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !test_valid |-> !test_bit);

endmodule

bind bitio_regfile bitio_regfile_chk #(
   .NUM_REGS (NUM_REGS),
   .DATA_W   (DATA_W),
   .BIT_REGS (BIT_REGS),
   .W1C_MASK (W1C_MASK),
   .RSV_MASK (RSV_MASK)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .bit_op_en  (bit_op_en),
   .bit_addr   (bit_addr),
   .rd_addr    (rd_addr),
   .rd_data    (rd_data),
   .test_addr  (test_addr),
   .test_idx   (test_idx),
   .test_bit   (test_bit),
   .test_valid (test_valid),
   .flag_set   (flag_set),
   .reg_flat   (reg_flat)
);

// File: tb/test_bitio_regfile.sv
`timescale 1ns/1ps
module test_bitio_regfile;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [5:0]   wr_addr = '0;
   logic [7:0]   wr_data = '0;
   logic [5:0]   rd_addr = '0;
   logic [7:0]   rd_data;
   logic         bit_op_en = 1'b0;
   logic         bit_op_set = 1'b0;
   logic [5:0]   bit_addr = '0;
   logic [2:0]   bit_idx = '0;
   logic [5:0]   test_addr = '0;
   logic [2:0]   test_idx = '0;
   logic         test_bit;
   logic         test_valid;
   logic [511:0] flag_set = '0;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   logic [7:0] mdl [64];

   always #10 clk = ~clk;   // 50 MHz

   bitio_regfile i_bitio_regfile (
      .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
      .bit_op_en, .bit_op_set, .bit_addr, .bit_idx,
      .test_addr, .test_idx, .test_bit, .test_valid, .flag_set
   );

   // Bit kinds per R2: 0 read/write, 1 flag, 2 reserved
   function automatic int kind_of(int a, int b);
      if ((a & 7) == 7) return 2;
      if ((a & 3) == 1) begin
         if (b < 4)  return 1;
         if (b == 7) return 2;
      end
      return 0;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle(logic [5:0] ra);
      wr_en = 0; bit_op_en = 0; flag_set = '0; rd_addr = ra;
   endtask

   // Update model with the inputs applied this cycle (R1, R3, R4, R5, R6, R8).
   task automatic model_update();
      logic [7:0] nx [64];
      for (int a = 0; a < 64; a++) begin
         nx[a] = mdl[a];
         for (int b = 0; b < 8; b++) begin
            bit wh, bh;
            wh = wr_en && (wr_addr == a);
            bh = bit_op_en && !wr_en && (bit_addr == a) && (a < 32) && (bit_idx == b);
            case (kind_of(a, b))
               0: if (wh) nx[a][b] = wr_data[b];
                  else if (bh) nx[a][b] = bit_op_set;
               1: if (flag_set[a*8+b]) nx[a][b] = 1'b1;
                  else if (wh && wr_data[b]) nx[a][b] = 1'b0;
                  else if (bh && bit_op_set) nx[a][b] = 1'b0;
               default: nx[a][b] = 1'b0;
            endcase
         end
      end
      for (int a = 0; a < 64; a++) mdl[a] = nx[a];
   endtask

   // Inputs were driven at a falling edge; check outputs, then clock.
   task automatic step(string tag);
      logic [7:0] w;
      #1;
      check(tag, rd_data, mdl[rd_addr]);
      w = mdl[test_addr];
      check("R7 valid", test_valid, test_addr < 32);
      check("R7 bit", test_bit, (test_addr < 32) ? w[test_idx] : 1'b0);
      model_update();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic expect_rd(string tag, logic [5:0] a, logic [7:0] exp);
      idle(a);
      #1;
      check(tag, rd_data, exp);
      step(tag);
   endtask

   task automatic bop(logic [5:0] a, logic [2:0] i, logic s);
      idle(0);
      bit_op_en = 1; bit_addr = a; bit_idx = i; bit_op_set = s;
      step("R5 op");
   endtask

   task automatic wr(logic [5:0] a, logic [7:0] d);
      idle(0);
      wr_en = 1; wr_addr = a; wr_data = d;
      step("R1 op");
   endtask

   initial begin
      for (int a = 0; a < 64; a++) mdl[a] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R9: reset state
      for (int a = 0; a < 64; a++) begin
         rd_addr = a[5:0];
         #1;
         check("R9", rd_data, 8'h00);
      end

      // R1
      wr(6'h10, 8'hA5);
      expect_rd("R1", 6'h10, 8'hA5);
      // R2: reserved address and reserved bit
      wr(6'h07, 8'hFF);
      expect_rd("R2", 6'h07, 8'h00);
      wr(6'h01, 8'hFF);
      expect_rd("R2", 6'h01, 8'h70);
      // R3: flags raised, write-one clears, non-flag set input ignored
      idle(0); flag_set[8] = 1; flag_set[10] = 1; step("R3 op");
      expect_rd("R3", 6'h01, 8'h75);
      wr(6'h01, 8'h01);
      expect_rd("R3", 6'h01, 8'h04);
      idle(0); flag_set[13] = 1; step("R3 op");
      expect_rd("R3", 6'h01, 8'h04);
      // R4: set beats clear
      idle(0); wr_en = 1; wr_addr = 6'h01; wr_data = 8'h02; flag_set[9] = 1;
      step("R4 op");
      expect_rd("R4", 6'h01, 8'h06);
      // R5: bit set on flag clears only that flag
      bop(6'h01, 3'd1, 1'b1);
      expect_rd("R5", 6'h01, 8'h04);
      bop(6'h01, 3'd2, 1'b0);
      expect_rd("R5", 6'h01, 8'h04);
      bop(6'h10, 3'd6, 1'b1);
      expect_rd("R5", 6'h10, 8'hE5);
      bop(6'h10, 3'd0, 1'b0);
      expect_rd("R5", 6'h10, 8'hE4);
      // R6: bit op above 0x1F ignored
      wr(6'h22, 8'h00);
      bop(6'h22, 3'd3, 1'b1);
      expect_rd("R6", 6'h22, 8'h00);
      wr(6'h20, 8'hFF);
      bop(6'h20, 3'd0, 1'b0);
      expect_rd("R6", 6'h20, 8'hFF);
      // R7: test in and out of range
      idle(0); test_addr = 6'h10; test_idx = 3'd2; #1;
      check("R7", {test_valid, test_bit}, 2'b11);
      test_idx = 3'd0; #1;
      check("R7", {test_valid, test_bit}, 2'b10);
      test_addr = 6'h20; #1;
      check("R7", {test_valid, test_bit}, 2'b00);
      // R8: byte write drops a simultaneous bit op
      idle(0); wr_en = 1; wr_addr = 6'h12; wr_data = 8'h0F;
      bit_op_en = 1; bit_addr = 6'h12; bit_idx = 3'd7; bit_op_set = 1;
      step("R8 op");
      expect_rd("R8", 6'h12, 8'h0F);

      // Constrained random mix, fixed seed
      void'($urandom(32'h5EED_0042));
      for (int n = 0; n < 4000; n++) begin
         idle($urandom_range(0, 63));
         wr_en      = ($urandom_range(0, 9) < 4);
         wr_addr    = ($urandom_range(0, 1) != 0) ? 6'($urandom_range(0, 31)) : 6'($urandom);
         wr_data    = 8'($urandom);
         bit_op_en  = ($urandom_range(0, 9) < 5);
         bit_addr   = ($urandom_range(0, 3) != 0) ? 6'($urandom_range(0, 33)) : 6'($urandom);
         bit_idx    = 3'($urandom);
         bit_op_set = 1'($urandom);
         test_addr  = 6'($urandom_range(0, 40));
         test_idx   = 3'($urandom);
         if ($urandom_range(0, 9) < 3) flag_set[$urandom_range(0, 511)] = 1'b1;
         step("R1 random");
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule